// File: doc/BRIEF.md
# Collision-Avoiding Mailbox Message Sender

This block sends one message through a 32-bit register that two agents share, one on each side of a host/guest boundary. Each side owns one 16-bit half: the host writes its messages into bits 15:0 and the guest into bits 31:16. Bit 0 of each half is a doorbell that raises an interrupt at the other agent. Before it writes, the sender claims the register. It stamps a signature into bits 15:1 of the other side's half, waits a detection interval, and then reads the register back to confirm that nobody else is using it. The side is chosen by a parameter.

If the claim is intact, the sender writes its payload with the doorbell set. It then polls the register until the peer clears that doorbell. If the claim was disturbed, it backs off and tries again, up to a bounded number of retries. When the transaction ends, the claim field is cleared and exactly one status pulse is raised: delivered, retries exhausted, or no acknowledge. All delays are counted in time units of `TICK_CYC` clock cycles.

Register accesses use a simple master port. A write is a single-cycle strobe with a per-bit mask. A read is a single-cycle strobe whose data is valid on `reg_rdata_i` in the following cycle.

Top module: `mbx_send`

## Requirements
- R1: After reset and until a request arrives, `busy_o`, `reg_we_o`, `reg_re_o`, `done_o`, `err_o` and `timeout_o` are all low.
- R2: The cycle in which `send_req_i` is seen while idle carries the claim write. For the host side the mask is 0xFFFE0000 and the data is 0x6AC20000. For the guest side the mask is 0x0000FFFE and the data is 0x00006AC2. The signature is `CLAIM_SIG`, default 0x6AC2.
- R3: Every claim write is followed, exactly DETECT_UNITS×TICK_CYC cycles later, by an ownership read. No other register access happens in between.
- R4: The readback counts as a collision when the claim field in the peer half (bits 31:17 on the host side) no longer equals the signature. It also counts as one when the sender's own bits 15:1 (host side) hold the signature.
- R5: After a collision, while fewer than MAX_RETRIES retries have been used, the claim write is repeated RETRY_UNITS×TICK_CYC+1 cycles after the ownership read.
- R6: Two cycles after a collision-free ownership read, the sender writes its own half with mask 0x0000FFFF (host side). The data is {payload, 1'b1}, so bit 0 is the doorbell.
- R7: The first acknowledge poll reads the register ACK_UNITS×TICK_CYC cycles after the message write. Each later poll follows the previous one by ACK_UNITS×TICK_CYC+1 cycles. A readback with the own doorbell bit at 0 ends the transaction with `done_o`.
- R8: After ACK_MAX_POLLS polls that all show the doorbell still set, the transaction ends with `timeout_o`.
- R9: A collision on claim attempt MAX_RETRIES+1 ends the transaction with `err_o`, and no message write is made.
- R10: Every transaction ends with one write of zero into the peer claim field, using the claim mask. The single-cycle status pulse is raised in the same cycle, and `busy_o` is low in the next cycle.
- R11: While `busy_o` is high, `send_req_i` and `send_data_i` have no effect. No extra claim write is made, and the message sent is the payload that was accepted.
- R12: A read strobe and a write strobe are never raised in the same cycle, and at most one status output is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| send_req_i | input | 1 | Request to send; accepted only while idle |
| send_data_i | input | 15 | Payload placed above the doorbell bit in the own half |
| busy_o | output | 1 | A transaction is in progress |
| reg_we_o | output | 1 | Register write strobe |
| reg_wmask_o | output | 32 | Per-bit write enable |
| reg_wdata_o | output | 32 | Write data |
| reg_re_o | output | 1 | Register read strobe |
| reg_rdata_i | input | 32 | Read data, valid the cycle after `reg_re_o` |
| done_o | output | 1 | Pulse: message acknowledged |
| err_o | output | 1 | Pulse: collision retries exhausted |
| timeout_o | output | 1 | Pulse: acknowledge polls exhausted |

## Verification
The assertions assume that the register answers every read with data in the next cycle. They also assume that the payload never equals the signature's upper fifteen bits, so the sender's own half can never look like a peer claim. The stimulus keeps to both. The register model returns registered data one cycle after each read strobe. It clears the own claim field whenever it does not inject a collision, and the payloads are chosen away from the signature. Collisions are injected only at claim writes, alternating between erasing the peer claim and planting the peer's signature. Acknowledges are given only by clearing the doorbell on a chosen poll.

// File: rtl/mbx_send_pkg.sv
package mbx_send_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned HALF_W = REG_W / 2;
  localparam int unsigned MSG_W  = HALF_W - 1;

  typedef logic [REG_W-1:0] word_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DETECT, ST_OWN_CHK, ST_BACKOFF,
    ST_SEND, ST_ACK_WAIT, ST_ACK_CHK, ST_RELEASE
  } state_e;

  typedef enum logic [1:0] {RES_DONE, RES_ERR, RES_TMO} result_e;

  function automatic int unsigned own_lsb(bit guest);
    return guest ? HALF_W : 0;
  endfunction

  function automatic int unsigned peer_lsb(bit guest);
    return guest ? 0 : HALF_W;
  endfunction

  // claim field: a half without its doorbell bit
  function automatic word_t field_mask(int unsigned lsb);
    return word_t'({{(HALF_W-1){1'b1}}, 1'b0}) << lsb;
  endfunction

  function automatic word_t field_val(logic [HALF_W-1:0] sig, int unsigned lsb);
    return word_t'(sig & {{(HALF_W-1){1'b1}}, 1'b0}) << lsb;
  endfunction

  function automatic word_t half_mask(int unsigned lsb);
    return word_t'({HALF_W{1'b1}}) << lsb;
  endfunction
endpackage

// File: rtl/mbx_send_timer.sv
module mbx_send_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/mbx_send_cnt.sv
module mbx_send_cnt #(
  parameter int unsigned LIMIT = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic at_lim_o
);
  localparam int unsigned CW = $clog2(LIMIT + 2);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign at_lim_o = (cnt_q == CW'(LIMIT));
endmodule

// File: rtl/mbx_send_own_chk.sv
module mbx_send_own_chk
  import mbx_send_pkg::*;
#(
  parameter bit                GUEST_SIDE = 1'b0,
  parameter logic [HALF_W-1:0] CLAIM_SIG  = 16'h6AC2
) (
  input  word_t reg_rdata_i,
  output logic  bell_o,
  output logic  collide_o
);
  logic [HALF_W-2:0] peer_f, own_f;
  logic              unused_peer_bell;

  generate
    if (GUEST_SIDE) begin : g_guest
      assign peer_f           = reg_rdata_i[HALF_W-1:1];
      assign own_f            = reg_rdata_i[REG_W-1:HALF_W+1];
      assign bell_o           = reg_rdata_i[HALF_W];
      assign unused_peer_bell = reg_rdata_i[0];
    end else begin : g_host
      assign peer_f           = reg_rdata_i[REG_W-1:HALF_W+1];
      assign own_f            = reg_rdata_i[HALF_W-1:1];
      assign bell_o           = reg_rdata_i[0];
      assign unused_peer_bell = reg_rdata_i[HALF_W];
    end
  endgenerate

  // our claim overwritten, or the peer planted its own claim in our half
  assign collide_o = (peer_f != CLAIM_SIG[HALF_W-1:1]) || (own_f == CLAIM_SIG[HALF_W-1:1]);
endmodule

// File: rtl/mbx_send.sv
module mbx_send
  import mbx_send_pkg::*;
#(
  parameter bit                GUEST_SIDE    = 1'b0,
  parameter logic [HALF_W-1:0] CLAIM_SIG     = 16'h6AC2,
  parameter int unsigned       TICK_CYC      = 4,
  parameter int unsigned       DETECT_UNITS  = 10,
  parameter int unsigned       ACK_UNITS     = 2,
  parameter int unsigned       ACK_MAX_POLLS = 100,
  parameter int unsigned       RETRY_UNITS   = 5,
  parameter int unsigned       MAX_RETRIES   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              send_req_i,
  input  logic [MSG_W-1:0]  send_data_i,
  output logic              busy_o,
  output logic              reg_we_o,
  output logic [REG_W-1:0]  reg_wmask_o,
  output logic [REG_W-1:0]  reg_wdata_o,
  output logic              reg_re_o,
  input  logic [REG_W-1:0]  reg_rdata_i,
  output logic              done_o,
  output logic              err_o,
  output logic              timeout_o
);
  localparam int unsigned LEN_D   = DETECT_UNITS * TICK_CYC;
  localparam int unsigned LEN_A   = ACK_UNITS * TICK_CYC;
  localparam int unsigned LEN_R   = RETRY_UNITS * TICK_CYC;
  localparam int unsigned LEN_DA  = (LEN_D > LEN_A) ? LEN_D : LEN_A;
  localparam int unsigned LEN_MAX = (LEN_DA > LEN_R) ? LEN_DA : LEN_R;
  localparam int unsigned TMR_W   = $clog2(LEN_MAX + 1);
  localparam int unsigned OWN_LSB  = own_lsb(GUEST_SIDE);
  localparam int unsigned PEER_LSB = peer_lsb(GUEST_SIDE);
  localparam word_t PEER_CM = field_mask(PEER_LSB);
  localparam word_t PEER_CV = field_val(CLAIM_SIG, PEER_LSB);
  localparam word_t OWN_HM  = half_mask(OWN_LSB);
  localparam logic [TMR_W-1:0] LD_D = TMR_W'(LEN_D - 1);
  localparam logic [TMR_W-1:0] LD_A = TMR_W'(LEN_A - 1);
  localparam logic [TMR_W-1:0] LD_R = TMR_W'(LEN_R - 1);

  state_e             state_q, state_d;
  result_e            res_q, res_d;
  logic [MSG_W-1:0]   msg_q;
  logic               msg_ld;
  logic               tmr_load, tmr_zero;
  logic [TMR_W-1:0]   tmr_val;
  logic               rty_clr, rty_inc, rty_max;
  logic               pol_clr, pol_inc, pol_max;
  logic               rd_bell, rd_collide;

  mbx_send_timer #(.W(TMR_W)) u_timer (
    .clk_i, .rst_ni, .load_i(tmr_load), .load_val_i(tmr_val), .zero_o(tmr_zero)
  );

  mbx_send_cnt #(.LIMIT(MAX_RETRIES)) u_rty_cnt (
    .clk_i, .rst_ni, .clr_i(rty_clr), .inc_i(rty_inc), .at_lim_o(rty_max)
  );

  mbx_send_cnt #(.LIMIT(ACK_MAX_POLLS - 1)) u_pol_cnt (
    .clk_i, .rst_ni, .clr_i(pol_clr), .inc_i(pol_inc), .at_lim_o(pol_max)
  );

  mbx_send_own_chk #(.GUEST_SIDE(GUEST_SIDE), .CLAIM_SIG(CLAIM_SIG)) u_own_chk (
    .reg_rdata_i, .bell_o(rd_bell), .collide_o(rd_collide)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      res_q   <= RES_DONE;
      msg_q   <= '0;
    end else begin
      state_q <= state_d;
      res_q   <= res_d;
      if (msg_ld) msg_q <= send_data_i;
    end
  end

  always_comb begin
    state_d     = state_q;
    res_d       = res_q;
    msg_ld      = 1'b0;
    reg_we_o    = 1'b0;
    reg_re_o    = 1'b0;
    reg_wmask_o = '0;
    reg_wdata_o = '0;
    tmr_load    = 1'b0;
    tmr_val     = '0;
    rty_clr     = 1'b0;
    rty_inc     = 1'b0;
    pol_clr     = 1'b0;
    pol_inc     = 1'b0;
    done_o      = 1'b0;
    err_o       = 1'b0;
    timeout_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (send_req_i) begin
        msg_ld      = 1'b1;
        rty_clr     = 1'b1;
        reg_we_o    = 1'b1;
        reg_wmask_o = PEER_CM;
        reg_wdata_o = PEER_CV;
        tmr_load    = 1'b1;
        tmr_val     = LD_D;
        state_d     = ST_DETECT;
      end
      ST_DETECT: if (tmr_zero) begin
        reg_re_o = 1'b1;
        state_d  = ST_OWN_CHK;
      end
      ST_OWN_CHK: begin
        if (!rd_collide) begin
          state_d = ST_SEND;
        end else if (rty_max) begin
          res_d   = RES_ERR;
          state_d = ST_RELEASE;
        end else begin
          rty_inc  = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = LD_R;
          state_d  = ST_BACKOFF;
        end
      end
      ST_BACKOFF: if (tmr_zero) begin
        reg_we_o    = 1'b1;
        reg_wmask_o = PEER_CM;
        reg_wdata_o = PEER_CV;
        tmr_load    = 1'b1;
        tmr_val     = LD_D;
        state_d     = ST_DETECT;
      end
      ST_SEND: begin
        reg_we_o    = 1'b1;
        reg_wmask_o = OWN_HM;
        reg_wdata_o = word_t'({msg_q, 1'b1}) << OWN_LSB;
        pol_clr     = 1'b1;
        tmr_load    = 1'b1;
        tmr_val     = LD_A;
        state_d     = ST_ACK_WAIT;
      end
      ST_ACK_WAIT: if (tmr_zero) begin
        reg_re_o = 1'b1;
        state_d  = ST_ACK_CHK;
      end
      ST_ACK_CHK: begin
        if (!rd_bell) begin
          res_d   = RES_DONE;
          state_d = ST_RELEASE;
        end else if (pol_max) begin
          res_d   = RES_TMO;
          state_d = ST_RELEASE;
        end else begin
          pol_inc  = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = LD_A;
          state_d  = ST_ACK_WAIT;
        end
      end
      ST_RELEASE: begin
        reg_we_o    = 1'b1;
        reg_wmask_o = PEER_CM;
        reg_wdata_o = '0;
        done_o      = (res_q == RES_DONE);
        err_o       = (res_q == RES_ERR);
        timeout_o   = (res_q == RES_TMO);
        state_d     = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/mbx_send_chk.sv
module mbx_send_chk
  import mbx_send_pkg::*;
#(
  parameter bit                GUEST_SIDE = 1'b0,
  parameter logic [HALF_W-1:0] CLAIM_SIG  = 16'h6AC2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             send_req_i,
  input logic             busy_o,
  input logic             reg_we_o,
  input logic [REG_W-1:0] reg_wmask_o,
  input logic [REG_W-1:0] reg_wdata_o,
  input logic             reg_re_o,
  input logic             done_o,
  input logic             err_o,
  input logic             timeout_o
);
  localparam word_t PEER_CM = field_mask(peer_lsb(GUEST_SIDE));
  localparam word_t PEER_CV = field_val(CLAIM_SIG, peer_lsb(GUEST_SIDE));
  localparam word_t OWN_HM  = half_mask(own_lsb(GUEST_SIDE));
  localparam int unsigned BELL = own_lsb(GUEST_SIDE);

  logic status;
  assign status = done_o | err_o | timeout_o;

  AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_o && reg_re_o)); // R12

  AST_STATUS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, err_o, timeout_o})); // R12

  AST_STATUS_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status |-> (reg_we_o && reg_wmask_o == PEER_CM && reg_wdata_o == '0)); // R10

  AST_IDLE_AFTER_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status |=> !busy_o); // R10

  AST_CLAIM_PATTERN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o && reg_wmask_o == PEER_CM && !status) |-> (reg_wdata_o == PEER_CV)); // R2

  AST_DOORBELL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o && reg_wmask_o == OWN_HM) |-> reg_wdata_o[BELL]); // R6

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && send_req_i) |=> busy_o); // R11
endmodule

bind mbx_send mbx_send_chk #(.GUEST_SIDE(GUEST_SIDE), .CLAIM_SIG(CLAIM_SIG)) u_mbx_send_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .send_req_i(send_req_i), .busy_o(busy_o),
  .reg_we_o(reg_we_o), .reg_wmask_o(reg_wmask_o), .reg_wdata_o(reg_wdata_o),
  .reg_re_o(reg_re_o), .done_o(done_o), .err_o(err_o), .timeout_o(timeout_o)
);

// File: tb/mbx_send_bench.sv
module mbx_send_bench;
  import mbx_send_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int TICK    = 2;
  localparam int DET_U   = 10;
  localparam int ACK_U   = 2;
  localparam int POLLS   = 100;
  localparam int RET_U   = 5;
  localparam int RETRIES = 3;
  localparam bit GUEST   = 1'b0;
  localparam logic [HALF_W-1:0] SIG = 16'h6AC2;
  localparam int LEN_D = DET_U * TICK;
  localparam int LEN_A = ACK_U * TICK;
  localparam int LEN_R = RET_U * TICK;
  localparam int WDOG  = 20000;
  localparam word_t PEER_CM = field_mask(peer_lsb(GUEST));
  localparam word_t PEER_CV = field_val(SIG, peer_lsb(GUEST));
  localparam word_t OWN_CM  = field_mask(own_lsb(GUEST));
  localparam word_t OWN_CV  = field_val(SIG, own_lsb(GUEST));
  localparam word_t OWN_HM  = half_mask(own_lsb(GUEST));
  localparam int    BELL    = own_lsb(GUEST);
  localparam int K_DONE = 0, K_ERR = 1, K_TMO = 2;

  logic clk, rst_n, send_req, busy, we, re, done, err, tmo;
  logic [MSG_W-1:0] send_data;
  word_t wmask, wdata, rdata;

  mbx_send #(
    .GUEST_SIDE(GUEST), .CLAIM_SIG(SIG), .TICK_CYC(TICK), .DETECT_UNITS(DET_U),
    .ACK_UNITS(ACK_U), .ACK_MAX_POLLS(POLLS), .RETRY_UNITS(RET_U), .MAX_RETRIES(RETRIES)
  ) u_mbx_send (
    .clk_i(clk), .rst_ni(rst_n), .send_req_i(send_req), .send_data_i(send_data),
    .busy_o(busy), .reg_we_o(we), .reg_wmask_o(wmask), .reg_wdata_o(wdata),
    .reg_re_o(re), .reg_rdata_i(rdata), .done_o(done), .err_o(err), .timeout_o(tmo)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int    kind;
    word_t data;
    int    claims;
    int    polls;
  } exp_t;
  exp_t sb_q[$];

  int cfg_coll, cfg_ack;
  int n_pushed, n_popped;
  bit fin;

  // register model with scripted peer
  word_t mem;
  int    m_claims, m_polls;
  bit    m_pend;
  initial begin
    mem = '0; m_claims = 0; m_polls = 0; m_pend = 1'b0; rdata = '0;
  end
  always @(posedge clk) begin
    if (rst_n && we) begin
      word_t nm;
      nm = (mem & ~wmask) | (wdata & wmask);
      if (wmask == PEER_CM && wdata == PEER_CV) begin
        if (m_claims < cfg_coll) begin
          if (m_claims % 2 == 1) nm = (nm & ~OWN_CM) | OWN_CV;
          else                   nm = nm & ~PEER_CM;
        end else begin
          nm = nm & ~OWN_CM;
        end
        m_claims++;
      end else if (wmask == PEER_CM) begin
        m_claims = 0;
        m_pend   = 1'b0;
      end else if (wmask == OWN_HM) begin
        m_pend  = 1'b1;
        m_polls = 0;
      end
      mem = nm;
    end
    if (rst_n && re) begin
      word_t v;
      v = mem;
      if (m_pend) begin
        m_polls++;
        if (cfg_ack > 0 && m_polls >= cfg_ack) begin
          mem[BELL] = 1'b0;
          v[BELL]   = 1'b0;
          m_pend    = 1'b0;
        end
      end
      rdata <= v;
    end
  end

  // monitor / scoreboard
  int n_checks, n_errs, cyc;
  int last_claim, last_rd, last_send, claims_seen, polls_seen, evt;
  bit r1_done, idle_chk;
  localparam int E_NONE = 0, E_CLAIM = 1, E_OWNRD = 2, E_SEND = 3, E_POLL = 4;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  initial begin
    n_checks = 0; n_errs = 0; cyc = 0; n_popped = 0;
    last_claim = 0; last_rd = 0; last_send = 0; claims_seen = 0; polls_seen = 0;
    evt = E_NONE; r1_done = 1'b0; idle_chk = 1'b0;
  end

  always @(negedge clk) begin
    cyc++;
    if (fin || cyc > WDOG) begin
      if (!fin) chk(1'b0, "watchdog", "run did not finish", cyc, WDOG);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
    if (rst_n) begin
      if (!r1_done) begin
        r1_done = 1'b1;
        chk({busy, we, re, done, err, tmo} == 6'b0, "R1", "outputs after reset",
            {busy, we, re, done, err, tmo}, 0);
      end
      if (idle_chk) begin
        idle_chk = 1'b0;
        chk(!busy, "R10", "busy after status", busy, 0);
      end
      if (we) begin
        if (wmask == PEER_CM && wdata == PEER_CV) begin
          chk(sb_q.size() > 0, "R11", "claim without accepted request", sb_q.size(), 1);
          if (claims_seen == 0)
            chk(send_req, "R2", "claim in request cycle", send_req, 1);
          else
            chk(evt == E_OWNRD && cyc - last_rd == LEN_R + 1, "R5", "reclaim delay",
                cyc - last_rd, LEN_R + 1);
          claims_seen++;
          last_claim = cyc;
          evt = E_CLAIM;
        end else if (wmask == PEER_CM && wdata == '0) begin
          chk(done | err | tmo, "R10", "status with release", {done, err, tmo}, 1);
        end else if (wmask == OWN_HM) begin
          chk(evt == E_OWNRD && cyc - last_rd == 2, "R6", "message write timing",
              cyc - last_rd, 2);
          if (sb_q.size() > 0)
            chk(wdata == sb_q[0].data, "R6", "message data", wdata, sb_q[0].data);
          last_send = cyc;
          evt = E_SEND;
        end else begin
          chk(1'b0, "R2", "unexpected write mask", wmask, PEER_CM);
        end
      end
      if (re) begin
        if (evt == E_CLAIM) begin
          chk(cyc - last_claim == LEN_D, "R3", "detect interval", cyc - last_claim, LEN_D);
          evt = E_OWNRD;
        end else if (evt == E_SEND) begin
          chk(cyc - last_send == LEN_A, "R7", "first poll delay", cyc - last_send, LEN_A);
          polls_seen++;
          evt = E_POLL;
        end else if (evt == E_POLL) begin
          chk(cyc - last_rd == LEN_A + 1, "R7", "poll spacing", cyc - last_rd, LEN_A + 1);
          polls_seen++;
        end else begin
          chk(1'b0, "R3", "read without claim", evt, E_CLAIM);
        end
        last_rd = cyc;
      end
      if (done | err | tmo) begin
        int k;
        k = done ? K_DONE : (err ? K_ERR : K_TMO);
        if (sb_q.size() == 0) begin
          chk(1'b0, "R11", "status without request", k, -1);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(k == e.kind, (e.kind == K_DONE) ? "R7" : ((e.kind == K_ERR) ? "R9" : "R8"),
              "outcome", k, e.kind);
          chk(claims_seen == e.claims, "R4", "claim attempts", claims_seen, e.claims);
          chk(polls_seen == e.polls, (e.kind == K_TMO) ? "R8" : "R7", "poll count",
              polls_seen, e.polls);
        end
        n_popped++;
        claims_seen = 0;
        polls_seen  = 0;
        evt = E_NONE;
        idle_chk = 1'b1;
      end
    end
  end

  task automatic run(input logic [MSG_W-1:0] d, input int ncoll, input int ack,
                     input int kind, input int claims, input int polls, input bit poke);
    exp_t e;
    @(negedge clk);
    cfg_coll = ncoll;
    cfg_ack  = ack;
    e.kind = kind; e.data = word_t'({d, 1'b1}) << own_lsb(GUEST);
    e.claims = claims; e.polls = polls;
    sb_q.push_back(e);
    n_pushed++;
    send_data = d;
    send_req  = 1'b1;
    @(negedge clk);
    send_req  = 1'b0;
    if (poke) begin  // R11: request while busy must be ignored
      repeat (5) @(negedge clk);
      send_data = ~d;
      send_req  = 1'b1;
      repeat (3) @(negedge clk);
      send_req  = 1'b0;
    end
    wait (n_popped == n_pushed);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    fin = 1'b0; n_pushed = 0; cfg_coll = 0; cfg_ack = 1;
    rst_n = 1'b0; send_req = 1'b0; send_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run(15'h1234, 0, 1, K_DONE, 1, 1, 1'b0);        // R7 immediate ack
    run(15'h0ABC, 0, 3, K_DONE, 1, 3, 1'b1);        // R11 with busy request
    run(15'h7001, 1, 1, K_DONE, 2, 1, 1'b0);        // R4 peer claim erased
    run(15'h0555, 2, 2, K_DONE, 3, 2, 1'b0);        // R4 peer signature planted
    run(15'h2222, RETRIES, 1, K_DONE, RETRIES + 1, 1, 1'b0);   // R5 last retry succeeds
    run(15'h1111, RETRIES + 1, 1, K_ERR, RETRIES + 1, 0, 1'b0); // R9
    run(15'h0F0F, 0, 0, K_TMO, 1, POLLS, 1'b0);     // R8
    fin = 1'b1;
  end
endmodule